// File: doc/BRIEF.md
# Serial Link Word Framer with CRC

The framer turns a stream of 32-bit link words into 16-bit transmitter words. Each output word carries a flag bit and a command strobe. Input words arrive on a valid/ready interface with a marker that says whether the word is data or control. Each word goes out as two consecutive 16-bit halves, upper half first, and no idle word is placed between the halves.

Data halves carry a high flag. A running 16-bit CRC is kept over every transmitted data half. Control words carry a low flag. Their lowest four bits are replaced by even-parity bits, one for each 7-bit group of the 28 meaningful bits.

When a control word is accepted and data has been sent since the last control word, three things go out in order: a CRC command word with the strobe high, then the checksum with the flag high, then the control word. The CRC then restarts from all ones. An input that simply runs dry never causes a checksum. A separate clear input presets the CRC when a reset command is seen.

Top module: `link_word_framer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_word`, `out_flag` and `out_strobe` are 0 and `in_ready` is 1. Reset presets the CRC to 0xFFFF and marks that no data has been sent.
- R2: A data word accepted at a clock edge (`in_valid && in_ready`, `in_is_ctrl`=0) appears on the outputs after that edge as bits [31:16]. On the next cycle bits [15:0] follow. Both cycles have `out_flag`=1 and `out_strobe`=0.
- R3: `in_ready` is 0 on every cycle where a low half, a checksum or a control half of an accepted word is still to be sent. It returns to 1 on the cycle that shows the last output word of that input word, so a data word can be accepted every second cycle.
- R4: A control word accepted when no data has been sent since reset or since the last checksum produces two outputs with `out_flag`=0 and `out_strobe`=0. The first is bits [31:16]. The second is bits [15:4] in positions [15:4], with parity bits in [3:0]. Input bits [3:0] are ignored.
- R5: In the second half of a control word, bit 3 is the XOR of input bits [31:25], bit 2 of [24:18], bit 1 of [17:11] and bit 0 of [10:4]. This gives even parity per group, so an all-zero control word has zero parity.
- R6: A control word accepted after data has been sent is preceded by a command word 0x0001 with `out_strobe`=1 and `out_flag`=0, then by the checksum with `out_flag`=1 and `out_strobe`=0. The two control halves of R4 then follow on consecutive cycles.
- R7: The checksum is the CRC register itself, not inverted. The CRC uses polynomial 0x1021 and is preset to 0xFFFF. Each data half updates it 16 bits at once, most significant bit first.
- R8: After a checksum is sent, the CRC is preset to 0xFFFF and the data-sent mark is cleared. A control word that directly follows another control word therefore gets no checksum.
- R9: `crc_clear` high at a clock edge presets the CRC to 0xFFFF. If a data half is being sent at that same edge, the preset wins over the update from that half. `crc_clear` does not change the data-sent mark.
- R10: On a cycle where nothing is accepted and nothing is pending, the next output is idle: `out_word`=0, `out_flag`=0 and `out_strobe`=0. An empty input never causes a command or a checksum word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Framer can take a word this cycle |
| in_word | input | 32 | Link word |
| in_is_ctrl | input | 1 | 1 = control word, 0 = data word |
| crc_clear | input | 1 | Reset command seen: preset the CRC |
| out_word | output | 16 | Transmitter word |
| out_flag | output | 1 | High for data halves and checksum |
| out_strobe | output | 1 | High for the CRC command word |

## Verification
Some rules are checked by the assertions on every cycle. They cover the framing after each accept: a data accept gives a flagged word, a control accept gives an unflagged word, and a strobe is always followed by a flagged checksum. They also cover the strobe only ever carrying code 0x0001, `in_ready` dropping after each accept, and idle output when nothing is offered. Only the bench scenarios can show that the values are right: the exact checksum over blocks of different lengths, the parity bits under a walking-one sweep of all 28 control bits, that an idle gap inserts no checksum, and that `crc_clear` wins over a simultaneous update.

// File: rtl/lwf_pkg.sv
package lwf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DATA_LO = 3'd1,
    ST_CSUM    = 3'd2,
    ST_CTL_HI  = 3'd3,
    ST_CTL_LO  = 3'd4
  } lwf_state_e;

endpackage

// File: rtl/lwf_crc.sv
module lwf_crc #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] INIT = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         preset,
  input  logic         upd_en,
  input  logic [W-1:0] upd_data,
  output logic [W-1:0] crc_q
);

  function automatic logic [W-1:0] crc_step(input logic [W-1:0] cur,
                                            input logic [W-1:0] din);
    logic [W-1:0] acc;
    logic         fb;
    acc = cur;
    for (int i = W - 1; i >= 0; i--) begin
      fb  = acc[W-1] ^ din[i];
      acc = {acc[W-2:0], 1'b0};
      if (fb) acc = acc ^ POLY;
    end
    return acc;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || preset) begin
      crc_q <= INIT;
    end else if (upd_en) begin
      crc_q <= crc_step(crc_q, upd_data);
    end
  end

endmodule

// File: rtl/lwf_parity.sv
module lwf_parity #(
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 7
) (
  input  logic [GROUPS*GROUP_W-1:0] field,
  output logic [GROUPS-1:0]         par
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign par[g] = ^field[g*GROUP_W +: GROUP_W];
  end

endmodule

// File: rtl/lwf_seq.sv
module lwf_seq
  import lwf_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int HALF_W   = 16,
  parameter int GROUPS   = 4,
  parameter int CMD_W    = 14,
  parameter int CMD_CODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_is_ctrl,
  output logic              in_ready,
  input  logic [HALF_W-1:0] crc_q,
  input  logic [GROUPS-1:0] par_bits,
  output logic [WORD_W-1:0] hold_word,
  output logic              crc_upd_en,
  output logic [HALF_W-1:0] crc_upd_data,
  output logic              crc_preset_req,
  output logic [HALF_W-1:0] out_word,
  output logic              out_flag,
  output logic              out_strobe
);

  localparam logic [HALF_W-1:0] CMD_WORD = HALF_W'(CMD_W'(CMD_CODE));

  lwf_state_e        state_q, state_d;
  logic              dirty_q, dirty_d;
  logic [WORD_W-1:0] hold_d;
  logic [HALF_W-1:0] nxt_word;
  logic              nxt_flag, nxt_strobe;
  logic              accept;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;

  always_comb begin
    state_d        = state_q;
    dirty_d        = dirty_q;
    hold_d         = hold_word;
    nxt_word       = '0;
    nxt_flag       = 1'b0;
    nxt_strobe     = 1'b0;
    crc_upd_en     = 1'b0;
    crc_upd_data   = '0;
    crc_preset_req = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          hold_d = in_word;
          if (!in_is_ctrl) begin
            nxt_word     = in_word[WORD_W-1:HALF_W];
            nxt_flag     = 1'b1;
            crc_upd_en   = 1'b1;
            crc_upd_data = in_word[WORD_W-1:HALF_W];
            dirty_d      = 1'b1;
            state_d      = ST_DATA_LO;
          end else if (dirty_q) begin
            nxt_word   = CMD_WORD;
            nxt_strobe = 1'b1;
            state_d    = ST_CSUM;
          end else begin
            nxt_word = in_word[WORD_W-1:HALF_W];
            state_d  = ST_CTL_LO;
          end
        end
      end
      ST_DATA_LO: begin
        nxt_word     = hold_word[HALF_W-1:0];
        nxt_flag     = 1'b1;
        crc_upd_en   = 1'b1;
        crc_upd_data = hold_word[HALF_W-1:0];
        state_d      = ST_IDLE;
      end
      ST_CSUM: begin
        nxt_word       = crc_q;
        nxt_flag       = 1'b1;
        crc_preset_req = 1'b1;
        dirty_d        = 1'b0;
        state_d        = ST_CTL_HI;
      end
      ST_CTL_HI: begin
        nxt_word = hold_word[WORD_W-1:HALF_W];
        state_d  = ST_CTL_LO;
      end
      ST_CTL_LO: begin
        nxt_word = {hold_word[HALF_W-1:GROUPS], par_bits};
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      dirty_q    <= 1'b0;
      hold_word  <= '0;
      out_word   <= '0;
      out_flag   <= 1'b0;
      out_strobe <= 1'b0;
    end else begin
      state_q    <= state_d;
      dirty_q    <= dirty_d;
      hold_word  <= hold_d;
      out_word   <= nxt_word;
      out_flag   <= nxt_flag;
      out_strobe <= nxt_strobe;
    end
  end

endmodule

// File: rtl/link_word_framer.sv
module link_word_framer #(
  parameter int          WORD_W   = 32,
  parameter int          PAR_GRPS = 4,
  parameter int          CMD_W    = 14,
  parameter int          CMD_CODE = 1,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_is_ctrl,
  input  logic              crc_clear,
  output logic [WORD_W/2-1:0] out_word,
  output logic              out_flag,
  output logic              out_strobe
);

  localparam int HALF_W  = WORD_W / 2;
  localparam int GROUP_W = (WORD_W - PAR_GRPS) / PAR_GRPS;

  logic [WORD_W-1:0]   hold_word;
  logic [HALF_W-1:0]   crc_q, crc_upd_data;
  logic                crc_upd_en, crc_preset_req;
  logic [PAR_GRPS-1:0] par_bits;

  lwf_seq #(
    .WORD_W  (WORD_W),
    .HALF_W  (HALF_W),
    .GROUPS  (PAR_GRPS),
    .CMD_W   (CMD_W),
    .CMD_CODE(CMD_CODE)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_word       (in_word),
    .in_is_ctrl    (in_is_ctrl),
    .in_ready      (in_ready),
    .crc_q         (crc_q),
    .par_bits      (par_bits),
    .hold_word     (hold_word),
    .crc_upd_en    (crc_upd_en),
    .crc_upd_data  (crc_upd_data),
    .crc_preset_req(crc_preset_req),
    .out_word      (out_word),
    .out_flag      (out_flag),
    .out_strobe    (out_strobe)
  );

  lwf_crc #(
    .W   (HALF_W),
    .POLY(HALF_W'(CRC_POLY)),
    .INIT(HALF_W'(CRC_INIT))
  ) u_crc (
    .clk     (clk),
    .rst     (rst),
    .preset  (crc_preset_req || crc_clear),
    .upd_en  (crc_upd_en),
    .upd_data(crc_upd_data),
    .crc_q   (crc_q)
  );

  lwf_parity #(
    .GROUPS (PAR_GRPS),
    .GROUP_W(GROUP_W)
  ) u_par (
    .field(hold_word[WORD_W-1:PAR_GRPS]),
    .par  (par_bits)
  );

endmodule

// File: rtl/link_word_framer_chk.sv
module link_word_framer_chk #(
  parameter int HALF_W   = 16,
  parameter int CMD_CODE = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_is_ctrl,
  input logic [HALF_W-1:0] out_word,
  input logic              out_flag,
  input logic              out_strobe
);

  assert_data_flagged_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_is_ctrl) |=> (out_flag && !out_strobe));

  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  assert_ctrl_unflagged_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_is_ctrl) |=> !out_flag);

  assert_cmd_code_R6: assert property (@(posedge clk) disable iff (rst)
    out_strobe |-> (!out_flag && out_word == HALF_W'(CMD_CODE)));

  assert_csum_follows_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    out_strobe |=> (out_flag && !out_strobe));

  assert_idle_output_R10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && in_ready) |=> (!out_flag && !out_strobe && out_word == '0));

endmodule

bind link_word_framer link_word_framer_chk #(
  .HALF_W  (WORD_W / 2),
  .CMD_CODE(CMD_CODE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_is_ctrl(in_is_ctrl),
  .out_word  (out_word),
  .out_flag  (out_flag),
  .out_strobe(out_strobe)
);

// File: tb/link_word_framer_test.sv
`timescale 1ns/1ps
module link_word_framer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        in_is_ctrl = 1'b0;
  logic        crc_clear = 1'b0;
  logic [15:0] out_word;
  logic        out_flag, out_strobe;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  logic [15:0] m_crc;
  logic        m_dirty;

  always #2 clk = ~clk;

  link_word_framer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_is_ctrl(in_is_ctrl), .crc_clear(crc_clear),
    .out_word(out_word), .out_flag(out_flag), .out_strobe(out_strobe)
  );

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = (r << 1) ^ 16'h1021;
      else r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [3:0] par_of(input logic [31:0] w);
    logic [3:0] p;
    p = '0;
    for (int g = 0; g < 4; g++)
      for (int b = 0; b < 7; b++)
        p[g] = p[g] ^ w[4 + 7*g + b];
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [15:0] w, input logic f,
                         input logic s);
    chk({out_word, out_flag, out_strobe} === {w, f, s}, req,
        {14'd0, out_word, out_flag, out_strobe}, {14'd0, w, f, s});
  endtask

  // Caller is at a negedge; returns at the negedge showing the last output word.
  task automatic send(input logic [31:0] w, input logic c, input logic clr);
    logic [15:0] ew[4];
    logic        ef[4], es[4];
    int          n;
    if (!c) begin
      ew[0] = w[31:16]; ef[0] = 1; es[0] = 0;
      ew[1] = w[15:0];  ef[1] = 1; es[1] = 0;
      n = 2;
      if (clr) m_crc = 16'hFFFF; else m_crc = crc_upd(m_crc, w[31:16]);
      m_crc = crc_upd(m_crc, w[15:0]);
      m_dirty = 1;
    end else begin
      if (clr) m_crc = 16'hFFFF;
      if (m_dirty) begin
        ew[0] = 16'h0001; ef[0] = 0; es[0] = 1;
        ew[1] = m_crc;    ef[1] = 1; es[1] = 0;
        ew[2] = w[31:16]; ef[2] = 0; es[2] = 0;
        ew[3] = {w[15:4], par_of(w)}; ef[3] = 0; es[3] = 0;
        n = 4;
        m_crc = 16'hFFFF;
        m_dirty = 0;
      end else begin
        ew[0] = w[31:16]; ef[0] = 0; es[0] = 0;
        ew[1] = {w[15:4], par_of(w)}; ef[1] = 0; es[1] = 0;
        n = 2;
      end
    end
    in_valid = 1; in_word = w; in_is_ctrl = c; crc_clear = clr;
    chk(in_ready === 1'b1, "R3 ready before accept", {31'd0, in_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; crc_clear = 0; in_word = 32'hDEAD_BEEF;
    for (int i = 0; i < n; i++) begin
      if (!c) chk_out("R2 data half", ew[i], ef[i], es[i]);
      else if (n == 4 && i < 2) chk_out("R6 R7 command/checksum", ew[i], ef[i], es[i]);
      else chk_out("R4 R5 control half", ew[i], ef[i], es[i]);
      if (i < n - 1) begin
        chk(in_ready === 1'b0, "R3 ready low while pending", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
      end else begin
        chk(in_ready === 1'b1, "R3 ready back on last word", {31'd0, in_ready}, 32'd1);
      end
    end
  endtask

  task automatic idle(input int k, input string req);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      chk_out(req, 16'h0000, 1'b0, 1'b0);
    end
  endtask

  initial begin
    m_crc = 16'hFFFF;
    m_dirty = 0;
    repeat (3) @(negedge clk);
    chk_out("R1 outputs in reset", 16'h0000, 1'b0, 1'b0);
    rst = 0;
    @(negedge clk);
    chk_out("R1 outputs after reset", 16'h0000, 1'b0, 1'b0);
    chk(in_ready === 1'b1, "R1 ready after reset", {31'd0, in_ready}, 32'd1);

    // R4 R5: walking one over all 28 control bits, junk in ignored low bits
    for (int i = 0; i < 28; i++) send((32'd1 << (4 + i)) | 32'hA, 1'b1, 1'b0);
    send(32'h0000_0000, 1'b1, 1'b0);  // R5 all-zero -> zero parity
    send(32'hFFFF_FFF5, 1'b1, 1'b0);
    send(32'h1234_5678, 1'b1, 1'b0);

    // R2 R6 R7 R8: blocks of 1..6 data words, each closed by a control word
    for (int blk = 1; blk <= 6; blk++) begin
      for (int k = 0; k < blk; k++)
        send((32'(blk * 7 + k) * 32'h9E37_79B9) ^ 32'h0F0F_3C3C, 1'b0, 1'b0);
      send(32'hC000_0010 + 32'(blk << 8), 1'b1, 1'b0);
      send(32'h5A5A_A5A0, 1'b1, 1'b0);  // R8 back-to-back control, no checksum
    end
    for (int k = 0; k < 4; k++) send(32'h0000_0000, 1'b0, 1'b0);
    send(32'hFFFF_FFFF, 1'b0, 1'b0);
    send(32'h8000_0000, 1'b1, 1'b0);

    // R10: empty input between data and control gives idle words, no checksum
    send(32'hCAFE_F00D, 1'b0, 1'b0);
    idle(6, "R10 idle while input empty");
    send(32'h0F00_0040, 1'b1, 1'b0);
    idle(3, "R10 idle after control");

    // R9: clear together with the upper data half wins over that update
    send(32'h1111_2222, 1'b0, 1'b0);
    send(32'h3333_4444, 1'b0, 1'b1);
    send(32'h5555_6666, 1'b0, 1'b0);
    send(32'h7000_0070, 1'b1, 1'b0);

    // R9: clear during idle presets CRC and keeps the data-sent mark
    send(32'hABCD_0123, 1'b0, 1'b0);
    crc_clear = 1;
    @(negedge clk);
    crc_clear = 0;
    m_crc = 16'hFFFF;
    chk_out("R9 R10 idle during clear", 16'h0000, 1'b0, 1'b0);
    send(32'h0123_4560, 1'b1, 1'b0);

    // R9: clear together with a control word
    send(32'h2468_ACE0, 1'b0, 1'b0);
    send(32'h1357_9BD0, 1'b1, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule